// File: doc/BRIEF.md
# Complex Sample Input Framer

This block sits in front of a block transform engine. It collects the time-domain complex samples of one transform block and writes each one as a single word to the write port of a block buffer. Each sample has an 8-bit two's complement real part and an 8-bit two's complement imaginary part. The two parts reach the block in one of two ways:

- **Shared-bus mode:** both parts travel on one bus, real part first and imaginary part on the next clock.
- **Parallel mode:** the real part has its own bus and arrives in the same clock as the imaginary part. One sample comes every second clock.

A start pulse lines up with the real part of the first sample and marks the start of a block. Once the last sample of the block has been written, the block raises a one-cycle ready strobe for the transform engine and returns to waiting for the next start. The transform and the buffer memory are outside this block.

An active-low asynchronous reset initialises the hardware. A separate active-low synchronous abort, sampled on the rising clock edge, drops any block in progress and returns the block to idle.

Top module: `cpx_in_framer`

## Requirements
- R1: After the asynchronous reset is released, `wr_en` and `blk_ready` are low and stay low until a start pulse arrives.
- R2: In shared-bus mode (`par_mode`=0 at the start edge), the real part is sampled from `din_main` in the start cycle and the imaginary part in the next cycle. `wr_data` is {real[15:8], imaginary[7:0]} and `wr_en` is high in the cycle after the imaginary part is sampled.
- R3: In parallel mode (`par_mode`=1 at the start edge), the real part is sampled from `din_re` and the imaginary part from `din_main` in the same cycle. Samples are taken on every second cycle counted from the start cycle. Bus values in the cycles between are ignored.
- R4: A block writes exactly N_SAMPLES words (default 2048) to addresses 0 up to N_SAMPLES-1 in arrival order. Consecutive writes are exactly two cycles apart.
- R5: A block starts only on a low-to-high transition of `start_in` while the block is idle. A start pulse 1 or 2 cycles long starts exactly one block.
- R6: A rising edge on `start_in` during collection is ignored and does not disturb the block in progress.
- R7: `blk_ready` is high for exactly one cycle, the cycle right after the final write. After that, no write occurs until the next start edge.
- R8: When `srst_n` is low at a rising clock edge, collection is dropped. `wr_en` and `blk_ready` are low in the following cycle, and no write and no ready strobe happens until a new start edge.
- R9: The mode is captured at the start edge. A change of `par_mode` during a block has no effect on that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst_n | input | 1 | Synchronous active-low abort |
| par_mode | input | 1 | 1 = parallel buses, 0 = shared bus; sampled at start |
| start_in | input | 1 | Start-of-block pulse, aligned with the first real part |
| din_main | input | SAMP_W | Shared bus (shared-bus mode) or imaginary part (parallel mode) |
| din_re | input | SAMP_W | Real part in parallel mode, ignored otherwise |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | $clog2(N_SAMPLES) | Buffer write address |
| wr_data | output | 2*SAMP_W | {real, imaginary} word |
| blk_ready | output | 1 | One-cycle block-complete strobe |

## Verification
The assertions assume that the source keeps to the framing rules:
- the data follows the start pulse without gaps;
- `par_mode` is steady around a start edge;
- the asynchronous reset is not used as the abort.

The stimulus drives every sample on a fixed two-cycle slot after the start. It fills the ignored cycles and the unused real bus with changing junk bytes. It raises `start_in` during a block only as a deliberate test of R6, and it toggles `par_mode` during a block only as a deliberate test of R9.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  typedef enum logic [0:0] {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } cfr_state_e;
endpackage

// File: rtl/cfr_edge.sv
module cfr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_out
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise_out = level_in & ~level_q;
endmodule

// File: rtl/cfr_seq.sv
module cfr_seq
  import cfr_pkg::*;
#(
  parameter int SAMP_W    = 8,
  parameter int N_SAMPLES = 2048,
  localparam int AW       = $clog2(N_SAMPLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_n,
  input  logic              start_rise,
  input  logic              par_mode,
  input  logic [SAMP_W-1:0] din_main,
  input  logic [SAMP_W-1:0] din_re,
  output logic              req_wr,
  output logic              req_last,
  output logic [AW-1:0]     req_addr,
  output logic [SAMP_W-1:0] req_re,
  output logic [SAMP_W-1:0] req_im
);
  localparam logic [AW-1:0] LAST_IDX = AW'(N_SAMPLES - 1);

  cfr_state_e        state_q, state_d;
  logic              phase_q, phase_d;
  logic              mode_q, mode_d;
  logic [AW-1:0]     cnt_q, cnt_d;
  logic [SAMP_W-1:0] hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    mode_d   = mode_q;
    cnt_d    = cnt_q;
    hold_d   = din_main;
    hold_en  = 1'b0;
    req_wr   = 1'b0;
    req_last = 1'b0;
    req_re   = hold_q;
    req_im   = din_main;

    unique case (state_q)
      ST_IDLE: begin
        if (start_rise) begin
          state_d = ST_COLLECT;
          mode_d  = par_mode;
          phase_d = 1'b1;
          if (par_mode) begin
            req_wr = 1'b1;
            req_re = din_re;
          end else begin
            hold_en = 1'b1;
          end
        end
      end
      ST_COLLECT: begin
        if (!phase_q) begin
          phase_d = 1'b1;
          if (mode_q) begin
            req_wr = 1'b1;
            req_re = din_re;
          end else begin
            hold_en = 1'b1;
          end
        end else begin
          phase_d = 1'b0;
          if (!mode_q) req_wr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (req_wr) begin
      if (cnt_q == LAST_IDX) begin
        req_last = 1'b1;
        cnt_d    = '0;
        state_d  = ST_IDLE;
        phase_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    if (!srst_n) begin
      state_d  = ST_IDLE;
      phase_d  = 1'b0;
      cnt_d    = '0;
      hold_en  = 1'b0;
      req_wr   = 1'b0;
      req_last = 1'b0;
    end
  end

  assign req_addr = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      mode_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end
endmodule

// File: rtl/cfr_wr_stage.sv
module cfr_wr_stage #(
  parameter int SAMP_W = 8,
  parameter int AW     = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst_n,
  input  logic                req_wr,
  input  logic                req_last,
  input  logic [AW-1:0]       req_addr,
  input  logic [SAMP_W-1:0]   req_re,
  input  logic [SAMP_W-1:0]   req_im,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [2*SAMP_W-1:0] wr_data,
  output logic                blk_ready
);
  logic                wr_en_d, last_d, ready_d, last_q;
  logic                word_en;
  logic [2*SAMP_W-1:0] word_d;

  always_comb begin
    wr_en_d = req_wr & srst_n;
    last_d  = req_last & srst_n;
    ready_d = last_q & srst_n;
    word_en = wr_en_d;
    word_d  = {req_re, req_im};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      last_q    <= 1'b0;
      blk_ready <= 1'b0;
    end else begin
      wr_en     <= wr_en_d;
      last_q    <= last_d;
      blk_ready <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (word_en) begin
      wr_addr <= req_addr;
      wr_data <= word_d;
    end
  end
endmodule

// File: rtl/cpx_in_framer.sv
module cpx_in_framer #(
  parameter int SAMP_W    = 8,
  parameter int N_SAMPLES = 2048,
  localparam int AW       = $clog2(N_SAMPLES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst_n,
  input  logic                par_mode,
  input  logic                start_in,
  input  logic [SAMP_W-1:0]   din_main,
  input  logic [SAMP_W-1:0]   din_re,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [2*SAMP_W-1:0] wr_data,
  output logic                blk_ready
);
  logic              start_rise;
  logic              req_wr, req_last;
  logic [AW-1:0]     req_addr;
  logic [SAMP_W-1:0] req_re, req_im;

  cfr_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (start_in),
    .rise_out (start_rise)
  );

  cfr_seq #(.SAMP_W(SAMP_W), .N_SAMPLES(N_SAMPLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_n     (srst_n),
    .start_rise (start_rise),
    .par_mode   (par_mode),
    .din_main   (din_main),
    .din_re     (din_re),
    .req_wr     (req_wr),
    .req_last   (req_last),
    .req_addr   (req_addr),
    .req_re     (req_re),
    .req_im     (req_im)
  );

  cfr_wr_stage #(.SAMP_W(SAMP_W), .AW(AW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst_n    (srst_n),
    .req_wr    (req_wr),
    .req_last  (req_last),
    .req_addr  (req_addr),
    .req_re    (req_re),
    .req_im    (req_im),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .blk_ready (blk_ready)
  );
endmodule

// File: rtl/cpx_in_framer_chk.sv
module cpx_in_framer_chk #(
  parameter int N_SAMPLES = 2048,
  parameter int AW        = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          blk_ready
);
  localparam logic [AW-1:0] LAST_IDX = AW'(N_SAMPLES - 1);

  // R7
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> ($past(wr_en) && $past(wr_addr) == LAST_IDX));

  // R7
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |=> !blk_ready);

  // R4
  write_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en, 2) && $past(srst_n, 1) && $past(srst_n, 2))
      |-> (wr_addr == AW'($past(wr_addr, 2) + 1'b1)));

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_n |=> (!wr_en && !blk_ready));

  // R7
  ready_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> !wr_en);
endmodule

bind cpx_in_framer cpx_in_framer_chk #(.N_SAMPLES(N_SAMPLES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_n    (srst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .blk_ready (blk_ready)
);

// File: tb/cpx_in_framer_test.sv
module cpx_in_framer_test;
  localparam int NS = 16;
  localparam int AW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n, srst_n, par_mode, start_in;
  logic [7:0]    din_main, din_re;
  logic          wr_en, blk_ready;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;

  int tests = 0;
  int fails = 0;
  int wr_cnt, rdy_cnt, seed;
  logic cur_par, prev_last, mon_on;

  always #5 clk = ~clk;

  cpx_in_framer #(.SAMP_W(8), .N_SAMPLES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .par_mode(par_mode),
    .start_in(start_in), .din_main(din_main), .din_re(din_re),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .blk_ready(blk_ready)
  );

  function automatic logic [7:0] exp_re(int s, int k);
    return 8'((k * 37 + s * 11 + 5) & 255);
  endfunction
  function automatic logic [7:0] exp_im(int s, int k);
    return 8'(((k * 101) ^ (s * 29)) + 3);
  endfunction
  function automatic logic [7:0] junk(int k);
    return 8'((k * 53) ^ 8'hA5);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (blk_ready) begin
        rdy_cnt++;
        check(prev_last, "R7", "ready not right after last write", 0, 1);
      end
      if (wr_en) begin
        check(int'(wr_addr) == wr_cnt, "R4", "write address", int'(wr_addr), wr_cnt);
        check(wr_data == {exp_re(seed, wr_cnt), exp_im(seed, wr_cnt)},
              cur_par ? "R3" : "R2", "write data", int'(wr_data),
              int'({exp_re(seed, wr_cnt), exp_im(seed, wr_cnt)}));
        wr_cnt++;
      end
      prev_last = wr_en && (int'(wr_addr) == NS - 1);
    end
  end

  // par: mode; len: start pulse length; mid: extra start edge in the block; flip: toggle par_mode mid-block
  task automatic run_block(bit par, int len, int s, bit mid, bit flip);
    seed = s; cur_par = par; wr_cnt = 0; rdy_cnt = 0; prev_last = 1'b0;
    par_mode = par;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      start_in = (k == 0);
      if (flip && k > 0) par_mode = ~par;
      din_main = par ? exp_im(s, k) : exp_re(s, k);
      din_re   = par ? exp_re(s, k) : junk(k);
      @(negedge clk);
      start_in = (k == 0 && len == 2) || (mid && k == NS / 2);
      din_main = par ? junk(k + 7) : exp_im(s, k);
      din_re   = junk(k + 3);
    end
    @(negedge clk);
    start_in = 1'b0;
    par_mode = par;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      din_main = junk(i + 40);
      din_re   = junk(i + 50);
    end
    // R4 exact count, R7 no trailing writes
    check(wr_cnt == NS, "R4", "writes per block", wr_cnt, NS);
    // R5 one block per pulse, R7 single ready
    check(rdy_cnt == 1, "R5", "ready strobes per block", rdy_cnt, 1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    mon_on = 1'b0;
    rst_n = 1'b0; srst_n = 1'b1; par_mode = 1'b0; start_in = 1'b0;
    din_main = 8'h00; din_re = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!wr_en && !blk_ready, "R1", "outputs after reset", {wr_en, blk_ready}, 0);
    mon_on = 1'b1;

    // R2 shared-bus, 1-cycle start
    run_block(1'b0, 1, 1, 1'b0, 1'b0);
    // R5 shared-bus, 2-cycle start
    run_block(1'b0, 2, 2, 1'b0, 1'b0);
    // R3 parallel, 1-cycle start
    run_block(1'b1, 1, 3, 1'b0, 1'b0);
    // R5 parallel, 2-cycle start
    run_block(1'b1, 2, 4, 1'b0, 1'b0);
    // R6 start edge mid-block, both modes
    run_block(1'b0, 1, 5, 1'b1, 1'b0);
    run_block(1'b1, 1, 6, 1'b1, 1'b0);
    // R9 mode change mid-block, both modes
    run_block(1'b0, 2, 7, 1'b0, 1'b1);
    run_block(1'b1, 1, 8, 1'b0, 1'b1);

    // R8 abort during a shared-bus block
    begin
      int snap;
      seed = 9; cur_par = 1'b0; wr_cnt = 0; rdy_cnt = 0; prev_last = 1'b0;
      par_mode = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        start_in = (k == 0);
        din_main = exp_re(9, k);
        @(negedge clk);
        start_in = 1'b0;
        din_main = exp_im(9, k);
      end
      srst_n = 1'b0;
      @(negedge clk);
      srst_n = 1'b1;
      check(!wr_en && !blk_ready, "R8", "outputs after abort", {wr_en, blk_ready}, 0);
      snap = wr_cnt;
      for (int i = 0; i < 2 * NS + 6; i++) begin
        @(negedge clk);
        din_main = junk(i);
      end
      check(wr_cnt == snap, "R8", "writes after abort", wr_cnt, snap);
      check(rdy_cnt == 0, "R8", "ready after abort", rdy_cnt, 0);
    end
    // R8 clean block after abort
    run_block(1'b1, 2, 10, 1'b0, 1'b0);
    run_block(1'b0, 1, 11, 1'b0, 1'b0);

    mon_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule